// File: doc/BRIEF.md
# Display Command Stream Decoder

The decoder takes a byte stream of bulk display commands and turns it into video register updates and pixel copy requests. Each command opens with the prefix byte 0xAF and a command code. The register-write command carries an index and a value. The copy command carries a source address, a pixel count and a destination address. The decoder keeps two register banks. Writes land in a shadow bank. A lock makes software stage a whole new video mode there, and the unlock command moves the whole staged set into the active bank at once. The active bank drives the timing, base-address, colour-depth and blanking outputs.

The input is valid/ready. A byte moves when `s_valid` and `s_ready` are both high at a rising clock edge. `s_ready` is high unless a copy request is still waiting at the output. The copy output is also valid/ready: `cp_valid` rises one cycle after the last byte of a copy command is accepted. It and its fields stay unchanged until a cycle with `cp_ready` high, and `s_ready` stays low for all of that time. Control and status outputs are plain levels.

Top module: `bulkcmd_decoder`

## Requirements
- R1: The byte sequence 0xAF, 0x20, index, value is a register write. When unlocked, the new value shows on the outputs in the cycle after the value byte is accepted.
- R2: A write of 0x00 to index 0xFF sets `o_locked`. While locked, register writes change only the shadow bank and no active output moves.
- R3: A write of 0xFF to index 0xFF clears `o_locked` and copies every staged register to the active outputs at that same clock edge.
- R4: `o_base16` is formed as {reg 0x20, reg 0x21, reg 0x22} and `o_base8` as {reg 0x26, reg 0x27, reg 0x28}, most significant byte first.
- R5: Timing field k (k = 0..11) is bits [16k+15:16k] of `o_timing`. Its high byte is at index 0x01+2k and its low byte at 0x02+2k. `o_pixclk` is the reverse: its low byte is at 0x1B and its high byte at 0x1C.
- R6: `o_depth` is register 0x00 (0 selects 16 bpp) and `o_blank` is register 0x1F.
- R7: The sequence 0xAF, 0x6A, then seven argument bytes is a copy. The arguments are a 3-byte source address (MSB first), a 1-byte count and a 3-byte destination address (MSB first). `cp_valid` rises in the cycle after the ninth byte is accepted.
- R8: While `cp_valid` is high and `cp_ready` is low, `cp_valid` and the copy fields hold and `s_ready` is low. The request clears after the edge where `cp_ready` is high.
- R9: A lone 0xAF (one with no following command) has no effect on any output. A following 0xAF starts the next command normally. Bytes other than 0xAF between commands are discarded.
- R10: A code byte other than 0x20, 0x6A or 0xAF after the prefix sets `o_err`, which stays set until reset. Parsing resumes at the next 0xAF.
- R11: After reset all active registers read zero, `o_locked`, `o_err` and `cp_valid` are low, and `s_ready` is high.
- R12: Writes to indices from 0x30 to 0xFE leave every output unchanged, and so do writes to 0xFF with a value other than 0x00 or 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Command byte valid |
| s_ready | output | 1 | Decoder can accept a byte |
| s_data | input | 8 | Command byte |
| cp_valid | output | 1 | Copy request pending |
| cp_ready | input | 1 | Copy request taken |
| cp_src | output | 24 | Copy source address |
| cp_cnt | output | 8 | Copy pixel count |
| cp_dst | output | 24 | Copy destination address |
| o_depth | output | 8 | Colour depth select |
| o_blank | output | 8 | Blanking mode |
| o_base16 | output | 24 | 16 bpp segment base |
| o_base8 | output | 24 | 8 bpp segment base |
| o_pixclk | output | 16 | Pixel clock in 5 kHz units |
| o_timing | output | 192 | Twelve 16-bit timing fields |
| o_locked | output | 1 | Register lock held |
| o_err | output | 1 | Sticky unknown-command flag |

## Verification
Some rules are checked on every cycle: the copy request holds under back-pressure, input is blocked while a request waits, the error flag stays set, and no active output moves while the lock is held. The bench scenarios cover the rest. They show byte order for each register, the atomic commit on unlock, the ignored padding byte and out-of-range writes, and resynchronisation after a bad code. A bank model in the bench covers long random mixes of lock, unlock and writes.

// File: rtl/bulkcmd_pkg.sv
package bulkcmd_pkg;
  localparam logic [7:0] CMD_PREFIX = 8'hAF;
  localparam logic [7:0] OP_REGWR   = 8'h20;
  localparam logic [7:0] OP_COPY    = 8'h6A;
  localparam logic [7:0] LOCK_INDEX = 8'hFF;
  localparam logic [7:0] LOCK_VAL   = 8'h00;
  localparam logic [7:0] UNLOCK_VAL = 8'hFF;
  localparam int         COPY_ARGS  = 7;

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_CODE,
    PS_REG,
    PS_COPY
  } pstate_t;
endpackage

// File: rtl/bulkcmd_parser.sv
module bulkcmd_parser
  import bulkcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic        in_ready,
  input  logic [7:0]  in_data,
  output logic        wr_en,
  output logic [7:0]  wr_idx,
  output logic [7:0]  wr_val,
  output logic        cp_fire,
  output logic [23:0] cp_src,
  output logic [7:0]  cp_cnt,
  output logic [23:0] cp_dst,
  output logic        err
);
  localparam int SHW = (COPY_ARGS - 1) * 8;

  pstate_t        st;
  logic [2:0]     cnt;
  logic [7:0]     idx_q;
  logic [SHW-1:0] sh;
  logic           acc;
  logic [SHW+7:0] full;

  always_comb begin
    acc     = in_valid && in_ready;
    full    = {sh, in_data};
    wr_en   = acc && (st == PS_REG) && (cnt == 3'd1);
    wr_idx  = idx_q;
    wr_val  = in_data;
    cp_fire = acc && (st == PS_COPY) && (cnt == 3'(COPY_ARGS - 1));
    cp_src  = full[55:32];
    cp_cnt  = full[31:24];
    cp_dst  = full[23:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= PS_IDLE;
      cnt   <= '0;
      idx_q <= '0;
      sh    <= '0;
      err   <= 1'b0;
    end else if (acc) begin
      unique case (st)
        PS_IDLE: if (in_data == CMD_PREFIX) st <= PS_CODE;
        PS_CODE: begin
          cnt <= '0;
          if (in_data == OP_REGWR)        st <= PS_REG;
          else if (in_data == OP_COPY)    st <= PS_COPY;
          else if (in_data == CMD_PREFIX) st <= PS_CODE;
          else begin
            err <= 1'b1;
            st  <= PS_IDLE;
          end
        end
        PS_REG: begin
          if (cnt == 3'd0) begin
            idx_q <= in_data;
            cnt   <= 3'd1;
          end else begin
            st <= PS_IDLE;
          end
        end
        PS_COPY: begin
          sh  <= {sh[SHW-9:0], in_data};
          cnt <= cnt + 3'd1;
          if (cnt == 3'(COPY_ARGS - 1)) st <= PS_IDLE;
        end
        default: st <= PS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bulkcmd_regbank.sv
module bulkcmd_regbank
  import bulkcmd_pkg::*;
#(
  parameter int NREG = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_idx,
  input  logic [7:0]        wr_val,
  output logic [NREG*8-1:0] act_flat,
  output logic              locked
);
  localparam int IW = $clog2(NREG);

  logic [7:0] shadow [NREG];
  logic [7:0] active [NREG];
  logic       in_range;

  assign in_range = (wr_idx < 8'(NREG));

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      for (int i = 0; i < NREG; i++) begin
        shadow[i] <= '0;
        active[i] <= '0;
      end
    end else if (wr_en) begin
      if (wr_idx == LOCK_INDEX) begin
        if (wr_val == LOCK_VAL) begin
          locked <= 1'b1;
        end else if (wr_val == UNLOCK_VAL) begin
          locked <= 1'b0;
          for (int i = 0; i < NREG; i++) active[i] <= shadow[i];
        end
      end else if (in_range) begin
        shadow[wr_idx[IW-1:0]] <= wr_val;
        if (!locked) active[wr_idx[IW-1:0]] <= wr_val;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign act_flat[g*8 +: 8] = active[g];
  end
endmodule

// File: rtl/bulkcmd_copyout.sv
module bulkcmd_copyout (
  input  logic        clk,
  input  logic        rst,
  input  logic        fire,
  input  logic [23:0] src_in,
  input  logic [7:0]  cnt_in,
  input  logic [23:0] dst_in,
  input  logic        cp_ready,
  output logic        cp_valid,
  output logic [23:0] cp_src,
  output logic [7:0]  cp_cnt,
  output logic [23:0] cp_dst,
  output logic        in_ready
);
  assign in_ready = !cp_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      cp_valid <= 1'b0;
      cp_src   <= '0;
      cp_cnt   <= '0;
      cp_dst   <= '0;
    end else if (fire) begin
      cp_valid <= 1'b1;
      cp_src   <= src_in;
      cp_cnt   <= cnt_in;
      cp_dst   <= dst_in;
    end else if (cp_valid && cp_ready) begin
      cp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bulkcmd_decoder.sv
module bulkcmd_decoder #(
  parameter int NREG      = 48,
  parameter int NTIM      = 12,
  parameter int TIM_BASE  = 1,
  parameter int PCLK_IDX  = 8'h1B,
  parameter int BLANK_IDX = 8'h1F,
  parameter int B16_IDX   = 8'h20,
  parameter int B8_IDX    = 8'h26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [7:0]       s_data,
  output logic             cp_valid,
  input  logic             cp_ready,
  output logic [23:0]      cp_src,
  output logic [7:0]       cp_cnt,
  output logic [23:0]      cp_dst,
  output logic [7:0]       o_depth,
  output logic [7:0]       o_blank,
  output logic [23:0]      o_base16,
  output logic [23:0]      o_base8,
  output logic [15:0]      o_pixclk,
  output logic [NTIM*16-1:0] o_timing,
  output logic             o_locked,
  output logic             o_err
);
  logic              wr_en;
  logic [7:0]        wr_idx, wr_val;
  logic              fire;
  logic [23:0]       f_src, f_dst;
  logic [7:0]        f_cnt;
  logic [NREG*8-1:0] act;

  bulkcmd_parser u_parser (
    .clk(clk), .rst(rst),
    .in_valid(s_valid), .in_ready(s_ready), .in_data(s_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
    .cp_fire(fire), .cp_src(f_src), .cp_cnt(f_cnt), .cp_dst(f_dst),
    .err(o_err)
  );

  bulkcmd_regbank #(.NREG(NREG)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
    .act_flat(act), .locked(o_locked)
  );

  bulkcmd_copyout u_copy (
    .clk(clk), .rst(rst),
    .fire(fire), .src_in(f_src), .cnt_in(f_cnt), .dst_in(f_dst),
    .cp_ready(cp_ready), .cp_valid(cp_valid),
    .cp_src(cp_src), .cp_cnt(cp_cnt), .cp_dst(cp_dst),
    .in_ready(s_ready)
  );

  // high byte at the even-offset index, low byte right after it
  for (genvar k = 0; k < NTIM; k++) begin : g_tim
    localparam int HI = TIM_BASE + 2 * k;
    assign o_timing[k*16 +: 16] = {act[HI*8 +: 8], act[(HI+1)*8 +: 8]};
  end

  assign o_depth  = act[0 +: 8];
  assign o_blank  = act[BLANK_IDX*8 +: 8];
  assign o_pixclk = {act[(PCLK_IDX+1)*8 +: 8], act[PCLK_IDX*8 +: 8]};
  assign o_base16 = {act[B16_IDX*8 +: 8], act[(B16_IDX+1)*8 +: 8], act[(B16_IDX+2)*8 +: 8]};
  assign o_base8  = {act[B8_IDX*8 +: 8], act[(B8_IDX+1)*8 +: 8], act[(B8_IDX+2)*8 +: 8]};
endmodule

// File: rtl/bulkcmd_decoder_chk.sv
module bulkcmd_decoder_chk (
  input logic         clk,
  input logic         rst,
  input logic         s_valid,
  input logic         s_ready,
  input logic         cp_valid,
  input logic         cp_ready,
  input logic [23:0]  cp_src,
  input logic [7:0]   cp_cnt,
  input logic [23:0]  cp_dst,
  input logic [7:0]   o_depth,
  input logic [7:0]   o_blank,
  input logic [23:0]  o_base16,
  input logic [23:0]  o_base8,
  input logic [15:0]  o_pixclk,
  input logic [191:0] o_timing,
  input logic         o_locked,
  input logic         o_err
);
  p_cp_hold_r8: assert property (@(posedge clk) disable iff (rst)
    cp_valid && !cp_ready |=> cp_valid && $stable(cp_src) && $stable(cp_cnt) && $stable(cp_dst));

  p_block_input_r8: assert property (@(posedge clk) disable iff (rst)
    cp_valid |-> !s_ready);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    o_err |=> o_err);

  p_locked_frozen_r2: assert property (@(posedge clk) disable iff (rst)
    o_locked |=> (!o_locked || ($stable(o_depth) && $stable(o_blank) && $stable(o_base16)
                  && $stable(o_base8) && $stable(o_pixclk) && $stable(o_timing))));

  p_copy_from_byte_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(cp_valid) |-> $past(s_valid && s_ready));
endmodule

bind bulkcmd_decoder bulkcmd_decoder_chk u_chk (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
  .cp_valid(cp_valid), .cp_ready(cp_ready), .cp_src(cp_src), .cp_cnt(cp_cnt),
  .cp_dst(cp_dst), .o_depth(o_depth), .o_blank(o_blank), .o_base16(o_base16),
  .o_base8(o_base8), .o_pixclk(o_pixclk), .o_timing(o_timing),
  .o_locked(o_locked), .o_err(o_err)
);

// File: tb/tb_bulkcmd_decoder.sv
`timescale 1ns/1ps
module tb_bulkcmd_decoder;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         s_valid = 1'b0;
  logic         s_ready;
  logic [7:0]   s_data = '0;
  logic         cp_valid;
  logic         cp_ready = 1'b1;
  logic [23:0]  cp_src, cp_dst;
  logic [7:0]   cp_cnt, o_depth, o_blank;
  logic [23:0]  o_base16, o_base8;
  logic [15:0]  o_pixclk;
  logic [191:0] o_timing;
  logic         o_locked, o_err;

  int errors = 0;
  int checks = 0;
  logic [7:0] m_sh [48];
  logic [7:0] m_act [48];
  logic       m_lk;

  always #2.5 clk = ~clk;

  bulkcmd_decoder dut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .cp_valid(cp_valid), .cp_ready(cp_ready), .cp_src(cp_src), .cp_cnt(cp_cnt),
    .cp_dst(cp_dst), .o_depth(o_depth), .o_blank(o_blank), .o_base16(o_base16),
    .o_base8(o_base8), .o_pixclk(o_pixclk), .o_timing(o_timing),
    .o_locked(o_locked), .o_err(o_err)
  );

  task automatic chk(input logic ok, input string req, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  task automatic send(input logic [7:0] b);
    s_data = b; s_valid = 1'b1;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic m_write(input logic [7:0] idx, input logic [7:0] val);
    if (idx == 8'hFF) begin
      if (val == 8'h00) m_lk = 1'b1;
      else if (val == 8'hFF) begin
        m_lk = 1'b0;
        for (int i = 0; i < 48; i++) m_act[i] = m_sh[i];
      end
    end else if (idx < 8'd48) begin
      m_sh[idx] = val;
      if (!m_lk) m_act[idx] = val;
    end
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] val);
    send(8'hAF); send(8'h20); send(idx); send(val);
    m_write(idx, val);
  endtask

  function automatic logic [191:0] exp_tim();
    logic [191:0] t;
    for (int k = 0; k < 12; k++) t[k*16 +: 16] = {m_act[1+2*k], m_act[2+2*k]};
    return t;
  endfunction

  task automatic check_all(input string req);
    chk(o_depth == m_act[0], {req, " depth"}, 192'(o_depth), 192'(m_act[0]));
    chk(o_blank == m_act[31], {req, " blank"}, 192'(o_blank), 192'(m_act[31]));
    chk(o_base16 == {m_act[32], m_act[33], m_act[34]}, {req, " base16"},
        192'(o_base16), 192'({m_act[32], m_act[33], m_act[34]}));
    chk(o_base8 == {m_act[38], m_act[39], m_act[40]}, {req, " base8"},
        192'(o_base8), 192'({m_act[38], m_act[39], m_act[40]}));
    chk(o_pixclk == {m_act[28], m_act[27]}, {req, " pixclk"},
        192'(o_pixclk), 192'({m_act[28], m_act[27]}));
    chk(o_timing == exp_tim(), {req, " timing"}, o_timing, exp_tim());
    chk(o_locked == m_lk, {req, " locked"}, 192'(o_locked), 192'(m_lk));
  endtask

  task automatic copy_cmd(input logic [23:0] src, input logic [7:0] n, input logic [23:0] dst);
    send(8'hAF); send(8'h6A);
    send(src[23:16]); send(src[15:8]); send(src[7:0]); send(n);
    send(dst[23:16]); send(dst[15:8]); send(dst[7:0]);
  endtask

  initial begin
    void'($urandom(32'd1357));
    m_lk = 1'b0;
    for (int i = 0; i < 48; i++) begin m_sh[i] = '0; m_act[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    check_all("R11");
    chk(s_ready && !cp_valid && !o_err, "R11 flags", 192'({s_ready, cp_valid, o_err}), 192'(3'b100));

    // R1 / R6 plain writes
    reg_wr(8'h00, 8'h01); reg_wr(8'h1F, 8'h03);
    check_all("R1 R6");

    // R4 base addresses
    reg_wr(8'h20, 8'h12); reg_wr(8'h21, 8'h34); reg_wr(8'h22, 8'h56);
    reg_wr(8'h26, 8'hAB); reg_wr(8'h27, 8'hCD); reg_wr(8'h28, 8'hEF);
    chk(o_base16 == 24'h123456, "R4 base16", 192'(o_base16), 192'(24'h123456));
    chk(o_base8 == 24'hABCDEF, "R4 base8", 192'(o_base8), 192'(24'hABCDEF));

    // R5 byte orders
    reg_wr(8'h01, 8'hA1); reg_wr(8'h02, 8'hB2);
    reg_wr(8'h17, 8'h0C); reg_wr(8'h18, 8'h0D);
    reg_wr(8'h1B, 8'h2C); reg_wr(8'h1C, 8'h01);
    chk(o_timing[15:0] == 16'hA1B2, "R5 timing0", 192'(o_timing[15:0]), 192'(16'hA1B2));
    chk(o_timing[191:176] == 16'h0C0D, "R5 timing11", 192'(o_timing[191:176]), 192'(16'h0C0D));
    chk(o_pixclk == 16'h012C, "R5 pixclk", 192'(o_pixclk), 192'(16'h012C));

    // R2 / R3 lock and atomic commit
    reg_wr(8'hFF, 8'h00);
    chk(o_locked == 1'b1, "R2 lock", 192'(o_locked), 192'(1));
    reg_wr(8'h20, 8'h77); reg_wr(8'h00, 8'h00); reg_wr(8'h09, 8'h44);
    chk(o_base16 == 24'h123456, "R2 frozen base16", 192'(o_base16), 192'(24'h123456));
    check_all("R2");
    reg_wr(8'hFF, 8'hFF);
    chk(o_base16 == 24'h773456 && o_depth == 8'h00, "R3 commit",
        192'({o_base16, o_depth}), 192'({24'h773456, 8'h00}));
    check_all("R3");

    // R12 ignored writes
    reg_wr(8'h30, 8'h99); reg_wr(8'hFE, 8'h99); reg_wr(8'hFF, 8'h5A);
    check_all("R12");

    // R9 lone prefix, stray bytes
    send(8'hAF);
    check_all("R9 pad");
    chk(!cp_valid && !o_err, "R9 no side effect", 192'({cp_valid, o_err}), 192'(0));
    reg_wr(8'h1F, 8'h05);
    chk(o_blank == 8'h05, "R9 after pad", 192'(o_blank), 192'(8'h05));
    send(8'h20); send(8'h00); send(8'h66);
    check_all("R9 stray");

    // R7 copy with ready high: pulse one cycle
    copy_cmd(24'h010203, 8'h04, 24'h0A0B0C);
    chk(cp_valid && cp_src == 24'h010203 && cp_cnt == 8'h04 && cp_dst == 24'h0A0B0C, "R7 copy",
        192'({cp_valid, cp_src, cp_cnt, cp_dst}), 192'({1'b1, 24'h010203, 8'h04, 24'h0A0B0C}));
    @(negedge clk);
    chk(!cp_valid && s_ready, "R7 release", 192'({cp_valid, s_ready}), 192'(2'b01));

    // R8 back-pressure
    cp_ready = 1'b0;
    copy_cmd(24'hFFEEDD, 8'hC3, 24'h102030);
    repeat (3) @(negedge clk);
    chk(cp_valid && !s_ready && cp_src == 24'hFFEEDD && cp_dst == 24'h102030, "R8 hold",
        192'({cp_valid, s_ready, cp_src, cp_dst}), 192'({2'b10, 24'hFFEEDD, 24'h102030}));
    cp_ready = 1'b1;
    @(negedge clk);
    chk(!cp_valid && s_ready, "R8 release", 192'({cp_valid, s_ready}), 192'(2'b01));

    // random copies
    for (int n = 0; n < 20; n++) begin
      logic [23:0] rs, rd; logic [7:0] rc;
      rs = 24'($urandom); rd = 24'($urandom); rc = 8'($urandom);
      copy_cmd(rs, rc, rd);
      chk(cp_valid && cp_src == rs && cp_cnt == rc && cp_dst == rd, "R7 random copy",
          192'({cp_valid, cp_src, cp_cnt, cp_dst}), 192'({1'b1, rs, rc, rd}));
      @(negedge clk);
    end

    // R10 unknown code, resync
    send(8'hAF); send(8'h55);
    chk(o_err == 1'b1, "R10 err set", 192'(o_err), 192'(1));
    send(8'h20); send(8'h00); send(8'h99);
    check_all("R10 resync");
    reg_wr(8'h00, 8'h07);
    chk(o_depth == 8'h07 && o_err, "R10 parse resumes", 192'({o_depth, o_err}), 192'({8'h07, 1'b1}));

    // random mix against bank model (R1 R2 R3 R12)
    for (int n = 0; n < 300; n++) begin
      int sel;
      sel = int'($urandom % 16);
      if (sel == 0) reg_wr(8'hFF, 8'h00);
      else if (sel == 1) reg_wr(8'hFF, 8'hFF);
      else reg_wr(8'($urandom % 52), 8'($urandom));
      check_all("R1 R2 R3 random");
    end

    finish_run();
  end
endmodule